// File: doc/BRIEF.md
# UART interrupt priority identification

This block is the interrupt arbiter of one UART channel. Seven condition sources come in from the rest of the channel: line-status errors, receive timeout, receive FIFO at or above its trigger, transmit holding register empty, modem-status change, flow-control character match, and RTS/CTS rising edges. Each source is kept as a pending flag with its own clearing rule and masked by its own enable bit. The highest-ranked enabled pending source is encoded into an 8-bit identification value, and an active-high interrupt output is driven with it.

Bits 7:6 of the value show whether the FIFOs are enabled. While the CPU holds the identification read strobe high, the presented value is frozen. Events that arrive during the read are still captured and show once the strobe drops. The datapath, the FIFOs and the timeout counter live elsewhere and are seen only as inputs.

A change on an input becomes visible on the outputs two clock edges later: one edge into the pending flags, one into the output register. A change on the enables shows one edge later.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir_out` is 8'h01 and `irq` is 0.
- R2: Bits 5:0 of `iir_out` identify the reported source: line status 000110, receive timeout 001100, receive data 000100, transmit ready 000010, modem status 000000, flow character 010000, RTS/CTS edge 100000, none 000001.
- R3: With several sources pending, the one reported is the highest in the order line status, receive timeout, receive data, transmit ready, modem status, flow character, RTS/CTS edge.
- R4: `src_en` bit i (0 = line status ... 6 = RTS/CTS edge, in R3 order) gates source i; a disabled source is never reported and never raises `irq`.
- R5: Bits 7:6 of `iir_out` read 11 when `fifo_en` is 1 and 00 when it is 0.
- R6: While `iir_rd` is high, `iir_out` and `irq` do not change; events seen during the read are reported after `iir_rd` falls.
- R7: Line status becomes pending while any `lsr_err` bit is 1; a `rd_lsr` pulse clears it only in a cycle where `lsr_err` is all zero.
- R8: Receive data is pending exactly while `rx_at_trig` is 1.
- R9: A `rx_tmo` pulse makes receive timeout pending until a `rd_rbr` pulse.
- R10: A rising edge of `thr_empty` makes transmit ready pending; a `wr_thr` pulse clears it, and so does an identification read, but only a read whose captured value reported transmit ready.
- R11: Any `msr_delta` bit pulse makes modem status pending until a `rd_msr` pulse; identification reads do not clear it.
- R12: Flow character (`xoff_hit`) and RTS/CTS edge (`flow_rise`) pendings are each cleared by an identification read that reported that source.
- R13: `irq` always equals the inverse of `iir_out[0]`, and both change two clock edges after a source input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO enable state, shown in bits 7:6 |
| src_en | input | 7 | Per-source enables, bit order as in R3 |
| lsr_err | input | 4 | Break, framing, parity and overrun levels |
| rx_at_trig | input | 1 | Receive FIFO count at or above trigger |
| rx_tmo | input | 1 | Receive timeout strobe |
| thr_empty | input | 1 | Transmit holding register empty level |
| msr_delta | input | 4 | Modem status change strobes |
| xoff_hit | input | 1 | Flow or special character match strobe |
| flow_rise | input | 2 | RTS and CTS rising-edge strobes |
| iir_rd | input | 1 | Identification read in progress |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| iir_out | output | 8 | Identification value |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check on every cycle that the value is frozen during a read and that `irq` tracks bit 0. They also check that an idle value carries the none code, that bits 7:6 are never split, and that the modem-status and transmit-write clears take effect. The ranking of every subset of pending sources, every enable mask, the latency, and the source-specific clearing rules can only be shown by the bench's scenarios. These rules include a line-status read while errors remain, and a transmit condition surviving a read that reported another source.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int LSW = 4,
  parameter int MSW = 4,
  parameter int FLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fifo_en,
  input  logic [6:0]     src_en,
  input  logic [LSW-1:0] lsr_err,
  input  logic           rx_at_trig,
  input  logic           rx_tmo,
  input  logic           thr_empty,
  input  logic [MSW-1:0] msr_delta,
  input  logic           xoff_hit,
  input  logic [FLW-1:0] flow_rise,
  input  logic           iir_rd,
  input  logic           rd_lsr,
  input  logic           rd_rbr,
  input  logic           rd_msr,
  input  logic           wr_thr,
  output logic [7:0]     iir_out,
  output logic           irq
);
  localparam logic [5:0] C_LS = 6'b000110;
  localparam logic [5:0] C_TO = 6'b001100;
  localparam logic [5:0] C_RX = 6'b000100;
  localparam logic [5:0] C_TX = 6'b000010;
  localparam logic [5:0] C_MS = 6'b000000;
  localparam logic [5:0] C_XO = 6'b010000;
  localparam logic [5:0] C_FL = 6'b100000;
  localparam logic [5:0] C_NONE = 6'b000001;

  logic [6:0] pend;
  logic [6:0] win;
  logic [5:0] code;
  logic       thr_d, rd_d;
  logic [7:0] iir_q;
  logic       irq_q;

  wire tx_rise  = thr_empty & ~thr_d;
  wire rd_start = iir_rd & ~rd_d;
  wire clr_tx   = rd_start && (iir_q[5:0] == C_TX);
  wire clr_xo   = rd_start && (iir_q[5:0] == C_XO);
  wire clr_fl   = rd_start && (iir_q[5:0] == C_FL);

  assign win = pend & src_en;

  always_comb begin
    if      (win[0]) code = C_LS;
    else if (win[1]) code = C_TO;
    else if (win[2]) code = C_RX;
    else if (win[3]) code = C_TX;
    else if (win[4]) code = C_MS;
    else if (win[5]) code = C_XO;
    else if (win[6]) code = C_FL;
    else             code = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      thr_d <= 1'b0;
      rd_d  <= 1'b0;
      iir_q <= {2'b00, C_NONE};
      irq_q <= 1'b0;
    end else begin
      thr_d   <= thr_empty;
      rd_d    <= iir_rd;
      pend[0] <= (|lsr_err) | (pend[0] & ~rd_lsr);
      pend[1] <= rx_tmo | (pend[1] & ~rd_rbr);
      pend[2] <= rx_at_trig;
      pend[3] <= tx_rise | (pend[3] & ~wr_thr & ~clr_tx);
      pend[4] <= (|msr_delta) | (pend[4] & ~rd_msr);
      pend[5] <= xoff_hit | (pend[5] & ~clr_xo);
      pend[6] <= (|flow_rise) | (pend[6] & ~clr_fl);
      if (!iir_rd) begin
        iir_q <= {{2{fifo_en}}, code};
        irq_q <= ~code[0];
      end
    end
  end

  assign iir_out = iir_q;
  assign irq     = irq_q;

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(iir_rd) |-> ($stable(iir_out) && $stable(irq))); // R6
  AST_IRQ_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ~iir_out[0]); // R13
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    iir_out[0] |-> (iir_out[5:1] == 5'd0)); // R2
  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    iir_out[7] == iir_out[6]); // R5
  AST_MS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !(|msr_delta)) |=> !pend[4]); // R11
  AST_TX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !tx_rise) |=> !pend[3]); // R10
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 0;
  logic [6:0] src_en = 7'h7f;
  logic [3:0] lsr_err = 0;
  logic rx_at_trig = 0, rx_tmo = 0, thr_empty = 0;
  logic [3:0] msr_delta = 0;
  logic xoff_hit = 0;
  logic [1:0] flow_rise = 0;
  logic iir_rd = 0, rd_lsr = 0, rd_rbr = 0, rd_msr = 0, wr_thr = 0;
  logic [7:0] iir_out;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_ident u_dut (.clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .src_en(src_en),
    .lsr_err(lsr_err), .rx_at_trig(rx_at_trig), .rx_tmo(rx_tmo), .thr_empty(thr_empty),
    .msr_delta(msr_delta), .xoff_hit(xoff_hit), .flow_rise(flow_rise), .iir_rd(iir_rd),
    .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr), .wr_thr(wr_thr),
    .iir_out(iir_out), .irq(irq));

  function automatic logic [7:0] exp_val(input logic [6:0] m, input logic fe);
    logic [5:0] c;
    c = 6'b000001;
    for (int i = 6; i >= 0; i--)
      if (m[i])
        case (i)
          0: c = 6'b000110; 1: c = 6'b001100; 2: c = 6'b000100; 3: c = 6'b000010;
          4: c = 6'b000000; 5: c = 6'b010000; default: c = 6'b100000;
        endcase
    return {{2{fe}}, c};
  endfunction

  task automatic chk(input string req, input logic [7:0] exp);
    total++;
    if (iir_out !== exp || irq !== ~exp[0]) begin
      bad++;
      $display("FAIL %s iir=%h irq=%b expected iir=%h irq=%b", req, iir_out, irq, exp, ~exp[0]);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_src(input logic tmo, input logic ms, input logic xo, input logic fl);
    rx_tmo = tmo; msr_delta = {3'b0, ms}; xoff_hit = xo; flow_rise = {fl, 1'b0};
    @(negedge clk);
    rx_tmo = 0; msr_delta = 0; xoff_hit = 0; flow_rise = 0;
  endtask

  task automatic strobe(input int which);
    case (which)
      0: rd_lsr = 1; 1: rd_rbr = 1; 2: rd_msr = 1; default: wr_thr = 1;
    endcase
    @(negedge clk);
    rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0;
  endtask

  task automatic iir_read(output logic [7:0] v);
    logic [7:0] first;
    first = iir_out;
    iir_rd = 1;
    @(negedge clk);
    v = iir_out;
    @(negedge clk);
    @(negedge clk);
    total++;
    if (iir_out !== first || v !== first) begin
      bad++;
      $display("FAIL R6 iir=%h expected %h held", iir_out, first);
    end
    iir_rd = 0;
    settle();
  endtask

  task automatic clear_all();
    logic [7:0] v;
    lsr_err = 0; rx_at_trig = 0;
    strobe(0); strobe(1); strobe(2); strobe(3);
    thr_empty = 0;
    settle();
    for (int k = 0; k < 4; k++)
      if (iir_out[0] == 0) iir_read(v);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    chk("R1", 8'h01);
    rst_n = 1;
    settle();
    chk("R1", 8'h01);
    fifo_en = 1; settle(); chk("R5", 8'hC1);
    fifo_en = 0; settle(); chk("R5", 8'h01);

    for (int m = 0; m < 128; m++) begin
      lsr_err = {3'b0, m[0]}; rx_at_trig = m[2]; thr_empty = m[3];
      pulse_src(m[1], m[4], m[5], m[6]);
      settle();
      chk("R3", exp_val(m[6:0], 1'b0));
      clear_all();
    end

    lsr_err = 4'h8; rx_at_trig = 1; thr_empty = 1;
    pulse_src(1, 1, 1, 1);
    for (int e = 0; e < 128; e++) begin
      src_en = e[6:0];
      @(negedge clk); @(negedge clk);
      chk("R4", exp_val(e[6:0], 1'b0));
    end
    src_en = 7'h7f;
    clear_all();
    chk("R4", 8'h01);

    // R13 latency
    pulse_src(0, 1, 0, 0);
    chk("R13", 8'h01);
    @(negedge clk);
    chk("R13", 8'h00);
    strobe(2); settle(); chk("R11", 8'h01);

    // R7 line status clearing
    lsr_err = 4'h2; settle(); chk("R7", 8'h06);
    strobe(0); settle(); chk("R7", 8'h06);
    lsr_err = 0; settle(); chk("R7", 8'h06);
    strobe(0); settle(); chk("R7", 8'h01);

    // R8 receive data level
    rx_at_trig = 1; settle(); chk("R8", 8'h04);
    rx_at_trig = 0; settle(); chk("R8", 8'h01);

    // R9 timeout
    pulse_src(1, 0, 0, 0); settle(); chk("R9", 8'h0C);
    strobe(1); settle(); chk("R9", 8'h01);

    // R10 / R11 transmit ready and modem
    thr_empty = 1; pulse_src(0, 1, 0, 0); settle(); chk("R10", 8'h02);
    iir_read(v); chk("R10", 8'h00);
    iir_read(v); chk("R11", 8'h00);
    strobe(2); settle(); chk("R11", 8'h01);
    thr_empty = 0; settle(); thr_empty = 1; rx_at_trig = 1; settle(); chk("R10", 8'h04);
    iir_read(v); rx_at_trig = 0; settle(); chk("R10", 8'h02);
    strobe(3); settle(); chk("R10", 8'h01);
    thr_empty = 0;

    // R6 hold during read, event recorded
    pulse_src(0, 0, 1, 0); settle(); chk("R12", 8'h10);
    iir_rd = 1;
    @(negedge clk);
    pulse_src(1, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R6", 8'h10);
    iir_rd = 0; settle(); chk("R6", 8'h0C);
    strobe(1); settle(); chk("R9", 8'h01);

    // R12 RTS/CTS edge
    pulse_src(0, 0, 0, 1); settle(); chk("R12", 8'h20);
    iir_read(v); chk("R12", 8'h01);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule